// File: doc/BRIEF.md
# Byte-Wide Asynchronous Serial Adapter

This block is a host-mapped asynchronous serial port with one transmitter and one receiver that share a single control word. The host writes a control byte to choose the number of serial clock ticks per bit, the character format, what the transmit side does with the request-to-send output and its interrupt, and whether a received character raises an interrupt. A status byte, read from the same address, reports buffer and error conditions. A second address reaches the transmit holding register on write and the receive buffer on read.

On the serial side a tick input paces both directions. Each bit lasts 1, 16 or 64 ticks. In the 16 and 64 tick modes the receiver checks the start bit again at its middle and then samples every later bit at its middle. The divide-by-1 mode assumes that the line is already aligned to the tick. Carrier-detect and clear-to-send are only mirrored into status. The remaining divide code is a master reset that holds both paths idle until the host writes another code.

Top module: `sio_port`

## Requirements
- R1: After rst_n the control word is 0x03, which is master reset. Status reads 0x02 plus the modem bits. irq is 0, txd is 1 and rts_out is 0.
- R2: Control bits [1:0] set the ticks per bit: code 0 gives 1, code 1 gives 16 and code 2 gives 64. Code 3 is master reset.
- R3: Control bits [4:2] pick the format. Codes 0 to 3 carry 7 data bits with parity: even with 2 stop bits, odd with 2, even with 1, and odd with 1. Codes 4 and 5 carry 8 data bits without parity, with 2 stop bits and with 1. Codes 6 and 7 carry 8 data bits with even and with odd parity and 1 stop bit. A frame is a 0 start bit, the data least significant bit first, the optional parity bit, and stop bits at 1.
- R4: When a character is received, status bit 0 is set and the data address returns the character. For 7-bit formats bit 7 of the returned byte is 0.
- R5: Status bit 6 is set when the received parity bit does not match the selected parity.
- R6: Status bit 4 is set when the first stop bit is sampled as 0.
- R7: A character that completes while status bit 0 is set sets status bit 5. The buffer keeps the older character.
- R8: Reading the data address clears status bits 0, 4, 5 and 6. Writing the data address clears status bit 1, which is set again once the transmitter takes the byte.
- R9: In the 16 and 64 tick modes, a low pulse on rxd that is shorter than half a bit does not start a character.
- R10: Control bits [6:5] set the transmit control. Value 2 drives rts_out high and the other values drive it low. Value 3 holds txd at 0.
- R11: irq is high when control bit 7 is set and status bit 0 or bit 5 is set. irq is also high when control bits [6:5] equal 1 and status bit 1 is set. Status bit 7 equals irq.
- R12: During master reset, status bits 0, 4, 5 and 6 are 0 and status bit 1 is 1. Writes to the data address are ignored and txd stays 1. After a non-reset divide code is written, characters pass again.
- R13: Status bit 2 mirrors cd_in and status bit 3 mirrors cts_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select |
| reg_sel | input | 1 | Address: 0 selects control/status, 1 selects data |
| wr_en | input | 1 | Write strobe, sampled on clk when sel is high |
| rd_en | input | 1 | Read strobe; a data read clears flags on the clk edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while sel and rd_en are high, otherwise 0 |
| irq | output | 1 | Interrupt request |
| ser_tick | input | 1 | Serial clock enable, one pulse per tick |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_out | output | 1 | Request-to-send line level |
| cts_in | input | 1 | Clear-to-send level, shown in status |
| cd_in | input | 1 | Carrier-detect level, shown in status |

## Verification
A data write lands in the holding register at edge W, and the shifter takes the byte at edge W+1. Bit k of the frame therefore sits on txd from edge W+1+P·k for P cycles, where P is the number of ticks per bit and ser_tick is high on every cycle. The bench samples each bit on the falling edge nearest its middle, at W+1+P·k+P/2, and compares it with a frame it builds from its own format table. Receive status changes at the middle of the first stop bit, so the bench polls status until bit 0 rises or allows a fixed margin past the frame end. Read-clear effects are looked for one edge after the read. Control-driven outputs such as rts_out, break and irq are checked one cycle after the control write.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef struct packed {
        logic nb8;    // 8 data bits when set, else 7
        logic par;    // parity bit present
        logic odd;    // odd parity when set
        logic stop2;  // two stop bits when set
    } fmt_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_st_e;

    localparam logic [1:0] DIV_RESET = 2'd3;

    function automatic fmt_t fmt_decode(input logic [2:0] code);
        fmt_t f;
        f.nb8   = code[2];
        f.par   = !code[2] || code[1];
        f.odd   = code[0];
        f.stop2 = code[2] ? (code[1:0] == 2'b00) : !code[1];
        return f;
    endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; #(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64,
    parameter int CW    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] div,
    input  fmt_t       fmt,
    input  logic       load,
    input  logic [7:0] ld_data,
    output logic       busy,
    output logic       line
);
    typedef struct packed {
        logic [11:0]   sh;
        logic [3:0]    left;
        logic [CW-1:0] cnt;
    } tx_st_t;

    tx_st_t q, d;
    logic [CW-1:0] per;
    logic [3:0]    nbits;
    logic [11:0]   frame;
    logic          pbit;

    always_comb begin
        case (div)
            2'd1:    per = CW'(DIV_A - 1);
            2'd2:    per = CW'(DIV_B - 1);
            default: per = '0;
        endcase
    end

    always_comb begin
        nbits = fmt.nb8 ? 4'd8 : 4'd7;
        pbit  = ^(ld_data & (fmt.nb8 ? 8'hFF : 8'h7F)) ^ fmt.odd;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++)
            if (i < int'(nbits)) frame[i+1] = ld_data[i];
        if (fmt.par) frame[nbits+4'd1] = pbit;
    end

    always_comb begin
        d = q;
        if (clr) begin
            d.sh   = '1;
            d.left = '0;
            d.cnt  = '0;
        end else if (load) begin
            d.sh   = frame;
            d.left = 4'd1 + nbits + {3'b0, fmt.par} + (fmt.stop2 ? 4'd2 : 4'd1);
            d.cnt  = per;
        end else if (tick && q.left != '0) begin
            if (q.cnt == '0) begin
                d.sh   = {1'b1, q.sh[11:1]};
                d.left = q.left - 4'd1;
                d.cnt  = per;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: '1, left: '0, cnt: '0};
        else        q <= d;
    end

    assign busy = (q.left != '0);
    assign line = busy ? q.sh[0] : 1'b1;

    // R3
    left_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.left <= 4'd11);

endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64,
    parameter int CW    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] div,
    input  fmt_t       fmt,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] dout,
    output logic       perr,
    output logic       ferr
);
    typedef struct packed {
        rx_st_e        st;
        logic [CW-1:0] cnt;
        logic [3:0]    idx;
        logic [7:0]    sh;
        logic          pbit;
        logic          done;
        logic [7:0]    dout;
        logic          perr;
        logic          ferr;
    } rx_st_t;

    localparam rx_st_t RX_RST = '{st: RX_IDLE, cnt: '0, idx: '0, sh: '0,
                                  pbit: 1'b0, done: 1'b0, dout: '0,
                                  perr: 1'b0, ferr: 1'b0};

    rx_st_t q, d;
    logic [CW-1:0] per, half;
    logic [3:0]    nbits;
    logic [7:0]    word;

    always_comb begin
        case (div)
            2'd1:    begin per = CW'(DIV_A - 1); half = CW'(DIV_A / 2 - 1); end
            2'd2:    begin per = CW'(DIV_B - 1); half = CW'(DIV_B / 2 - 1); end
            default: begin per = '0;             half = '0;                 end
        endcase
    end

    assign nbits = fmt.nb8 ? 4'd8 : 4'd7;
    assign word  = fmt.nb8 ? q.sh : {1'b0, q.sh[7:1]};

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (clr) begin
            d = RX_RST;
        end else if (tick) begin
            case (q.st)
                RX_IDLE: if (!rxd) begin
                    d.idx = '0;
                    if (div == 2'd0) begin d.st = RX_DATA;  d.cnt = '0;   end
                    else             begin d.st = RX_START; d.cnt = half; end
                end
                RX_START: begin
                    if (q.cnt != '0)  d.cnt = q.cnt - 1'b1;
                    else if (!rxd) begin d.st = RX_DATA; d.cnt = per; end
                    else              d.st = RX_IDLE;
                end
                default: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - 1'b1;
                    end else begin
                        d.cnt = per;
                        d.idx = q.idx + 4'd1;
                        if (q.idx < nbits) begin
                            d.sh = {rxd, q.sh[7:1]};
                        end else if (fmt.par && q.idx == nbits) begin
                            d.pbit = rxd;
                        end else begin
                            d.st   = RX_IDLE;
                            d.done = 1'b1;
                            d.dout = word;
                            d.ferr = !rxd;
                            d.perr = fmt.par && ((^word ^ q.pbit) != fmt.odd);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign done = q.done;
    assign dout = q.dout;
    assign perr = q.perr;
    assign ferr = q.ferr;

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= 4'd10);

endmodule

// File: rtl/sio_port.sv
module sio_port import sio_pkg::*; #(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    input  logic       ser_tick,
    output logic       txd,
    input  logic       rxd,
    output logic       rts_out,
    input  logic       cts_in,
    input  logic       cd_in
);
    localparam int CW = $clog2(DIV_B);

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] hold;
        logic [7:0] rbuf;
        logic       rx_full;
        logic       tx_empty;
        logic       ovr;
        logic       fe;
        logic       pe;
    } port_st_t;

    port_st_t   q, d;
    logic       mreset, data_wr, ctrl_wr, data_rd, ld;
    logic       tx_busy, tx_line, rx_done, rx_pe, rx_fe;
    logic [7:0] rx_byte, status;
    logic [1:0] tc;
    fmt_t       fmt;

    assign mreset  = (q.ctrl[1:0] == DIV_RESET);
    assign fmt     = fmt_decode(q.ctrl[4:2]);
    assign tc      = q.ctrl[6:5];
    assign ctrl_wr = sel && wr_en && !reg_sel;
    assign data_wr = sel && wr_en && reg_sel;
    assign data_rd = sel && rd_en && reg_sel;
    assign ld      = !q.tx_empty && !tx_busy && !mreset;

    sio_tx #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(mreset), .tick(ser_tick),
        .div(q.ctrl[1:0]), .fmt(fmt), .load(ld), .ld_data(q.hold),
        .busy(tx_busy), .line(tx_line));

    sio_rx #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(mreset), .tick(ser_tick),
        .div(q.ctrl[1:0]), .fmt(fmt), .rxd(rxd), .done(rx_done),
        .dout(rx_byte), .perr(rx_pe), .ferr(rx_fe));

    always_comb begin
        d = q;
        if (ld) d.tx_empty = 1'b1;
        if (ctrl_wr) d.ctrl = wdata;
        if (data_wr && !mreset) begin
            d.hold     = wdata;
            d.tx_empty = 1'b0;
        end
        if (data_rd) begin
            d.rx_full = 1'b0;
            d.ovr     = 1'b0;
            d.fe      = 1'b0;
            d.pe      = 1'b0;
        end
        if (rx_done) begin
            if (q.rx_full && !data_rd) begin
                d.ovr = 1'b1;
            end else begin
                d.rbuf    = rx_byte;
                d.rx_full = 1'b1;
                d.fe      = rx_fe;
                d.pe      = rx_pe;
            end
        end
        if (mreset) begin
            d.rx_full  = 1'b0;
            d.ovr      = 1'b0;
            d.fe       = 1'b0;
            d.pe       = 1'b0;
            d.tx_empty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ctrl: 8'h03, hold: '0, rbuf: '0, rx_full: 1'b0,
                           tx_empty: 1'b1, ovr: 1'b0, fe: 1'b0, pe: 1'b0};
        else        q <= d;
    end

    assign irq     = (q.ctrl[7] && (q.rx_full || q.ovr)) || (tc == 2'd1 && q.tx_empty);
    assign status  = {irq, q.pe, q.ovr, q.fe, cts_in, cd_in, q.tx_empty, q.rx_full};
    assign rdata   = (sel && rd_en) ? (reg_sel ? q.rbuf : status) : 8'h00;
    assign rts_out = (tc == 2'd2);
    assign txd     = (tc == 2'd3) ? 1'b0 : tx_line;

    // R7
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.rx_full));

    // R8
    wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !mreset) |=> !q.tx_empty);

    // R8
    rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_done) |=> !q.rx_full);

    // R12
    mrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> (q.tx_empty && !q.rx_full && !q.ovr && !tx_busy));

endmodule

// File: tb/sim_sio_port.sv
module sim_sio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, txd, rts_out;
    logic       ser_tick = 1'b1;
    logic       cts_in = 1'b1, cd_in = 1'b0;
    logic       loop = 1'b1, inj = 1'b1;
    logic       rxd;
    int         nvec = 0, nbad = 0;

    always #4 clk = ~clk;
    assign rxd = loop ? txd : inj;

    sio_port u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq),
        .ser_tick(ser_tick), .txd(txd), .rxd(rxd), .rts_out(rts_out),
        .cts_in(cts_in), .cd_in(cd_in));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; reg_sel = a; wr_en = 1'b1; wdata = v;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; reg_sel = a; rd_en = 1'b1;
        #1 v = rdata;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wait_rx(input int lim);
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < lim && !s[0]; i++) host_rd(1'b0, s);
    endtask

    // frame from format table: code -> data bits, parity (0 none,1 even,2 odd), stops
    function automatic void build(input int f, input logic [7:0] b,
                                  output logic [11:0] fr, output int len);
        int nb, pm, ns, k;
        case (f)
            0: begin nb = 7; pm = 1; ns = 2; end
            1: begin nb = 7; pm = 2; ns = 2; end
            2: begin nb = 7; pm = 1; ns = 1; end
            3: begin nb = 7; pm = 2; ns = 1; end
            4: begin nb = 8; pm = 0; ns = 2; end
            5: begin nb = 8; pm = 0; ns = 1; end
            6: begin nb = 8; pm = 1; ns = 1; end
            default: begin nb = 8; pm = 2; ns = 1; end
        endcase
        fr = '1;
        fr[0] = 1'b0;
        k = 0;
        for (int i = 0; i < nb; i++) begin
            fr[i+1] = b[i];
            k += int'(b[i]);
        end
        if (pm != 0) fr[nb+1] = (pm == 1) ? logic'(k % 2) : logic'((k + 1) % 2);
        len = 1 + nb + ((pm != 0) ? 1 : 0) + ns;
    endfunction

    task automatic tx_frame(input int p, input int f, input logic [7:0] b);
        logic [11:0] fr;
        int len;
        build(f, b, fr, len);
        host_wr(1'b1, b);
        repeat (1 + p / 2) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            chk($sformatf("R2 R3 txd bit%0d div%0d fmt%0d", k, p, f), {7'b0, txd}, {7'b0, fr[k]});
            repeat (p) @(negedge clk);
        end
        chk("R3 idle after stop", {7'b0, txd}, 8'h01);
    endtask

    task automatic inject(input int p, input logic [11:0] fr, input int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk) inj = fr[k];
            repeat (p - 1) @(negedge clk);
        end
        @(negedge clk) inj = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int pt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        host_rd(1'b0, v);
        chk("R1 status after reset", v, 8'h0A);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 txd", {7'b0, txd}, 8'h01);
        chk("R1 rts", {7'b0, rts_out}, 8'h00);

        // R13 modem bits
        cts_in = 1'b0; cd_in = 1'b1;
        host_rd(1'b0, v);
        chk("R13 status cd/cts", v, 8'h06);
        cts_in = 1'b1; cd_in = 1'b0;

        // R2 R3 R4 loopback sweep over divide codes and formats
        for (int dv = 0; dv < 3; dv++) begin
            pt = (dv == 0) ? 1 : (dv == 1) ? 16 : 64;
            for (int f = 0; f < 8; f++) begin
                host_wr(1'b0, 8'((f << 2) | dv));
                for (int bi = 0; bi < 3; bi++) begin
                    logic [7:0] b;
                    b = (bi == 0) ? 8'hB3 : (bi == 1) ? 8'h5C : 8'h80;
                    tx_frame(pt, f, b);
                    wait_rx(200);
                    host_rd(1'b0, v);
                    chk("R4 status after receive", v, 8'h0B);
                    host_rd(1'b1, v);
                    chk("R4 received data", v, (f < 4) ? (b & 8'h7F) : b);
                    host_rd(1'b0, v);
                    chk("R8 status after data read", v, 8'h0A);
                end
            end
        end

        // R9 short glitch in divide-by-16 mode
        loop = 1'b0;
        host_wr(1'b0, 8'h15);
        @(negedge clk) inj = 1'b0;
        repeat (4) @(negedge clk);
        inj = 1'b1;
        repeat (60) @(negedge clk);
        host_rd(1'b0, v);
        chk("R9 glitch ignored", v, 8'h0A);

        // R5 parity error, 7 data even 1 stop (code 2)
        host_wr(1'b0, 8'h09);
        inject(16, {2'b11, 1'b1, 1'b1, 7'h41, 1'b0}, 10);
        repeat (40) @(negedge clk);
        host_rd(1'b0, v);
        chk("R5 parity error status", v, 8'h4B);
        host_rd(1'b1, v);
        chk("R5 data with parity error", v, 8'h41);
        host_rd(1'b0, v);
        chk("R8 parity flag cleared", v, 8'h0A);

        // R6 framing error, 8 data no parity 1 stop (code 5)
        host_wr(1'b0, 8'h15);
        inject(16, {2'b11, 1'b0, 8'h5A, 1'b0}, 10);
        repeat (60) @(negedge clk);
        host_rd(1'b0, v);
        chk("R6 framing error status", v, 8'h1B);
        host_rd(1'b1, v);
        chk("R6 data with framing error", v, 8'h5A);
        host_rd(1'b0, v);
        chk("R8 framing flag cleared", v, 8'h0A);

        // R7 overrun keeps older character
        loop = 1'b1;
        host_wr(1'b0, 8'h14);
        host_wr(1'b1, 8'h11);
        wait_rx(100);
        host_wr(1'b1, 8'h22);
        repeat (30) @(negedge clk);
        host_rd(1'b0, v);
        chk("R7 overrun status", v, 8'h2B);
        host_rd(1'b1, v);
        chk("R7 older data kept", v, 8'h11);
        host_rd(1'b0, v);
        chk("R8 overrun cleared", v, 8'h0A);

        // R11 receive interrupt
        host_wr(1'b0, 8'h94);
        host_rd(1'b0, v);
        chk("R11 no irq while empty", {7'b0, irq}, 8'h00);
        host_wr(1'b1, 8'h33);
        wait_rx(100);
        chk("R11 rx irq", {7'b0, irq}, 8'h01);
        host_rd(1'b0, v);
        chk("R11 status bit7", v, 8'h8B);
        host_rd(1'b1, v);
        chk("R11 rx data", v, 8'h33);
        chk("R11 irq drops after read", {7'b0, irq}, 8'h00);

        // R11 transmit interrupt, R10 rts
        host_wr(1'b0, 8'h34);
        chk("R11 tx irq", {7'b0, irq}, 8'h01);
        host_rd(1'b0, v);
        chk("R11 status with tx irq", v, 8'h8A);
        chk("R10 rts low code1", {7'b0, rts_out}, 8'h00);
        host_wr(1'b0, 8'h54);
        chk("R10 rts high code2", {7'b0, rts_out}, 8'h01);
        chk("R11 no irq code2", {7'b0, irq}, 8'h00);

        // R10 break
        loop = 1'b0;
        host_wr(1'b0, 8'h74);
        for (int i = 0; i < 5; i++) begin
            chk("R10 break holds txd low", {7'b0, txd}, 8'h00);
            @(negedge clk);
        end
        chk("R10 rts low code3", {7'b0, rts_out}, 8'h00);
        host_wr(1'b0, 8'h14);
        chk("R10 txd idle after break", {7'b0, txd}, 8'h01);

        // R12 master reset
        loop = 1'b1;
        host_wr(1'b1, 8'h66);
        wait_rx(100);
        host_wr(1'b0, 8'h03);
        host_rd(1'b0, v);
        chk("R12 flags cleared", v, 8'h0A);
        host_wr(1'b1, 8'h77);
        host_rd(1'b0, v);
        chk("R12 data write ignored", v, 8'h0A);
        for (int i = 0; i < 20; i++) begin
            chk("R12 txd idle in reset", {7'b0, txd}, 8'h01);
            @(negedge clk);
        end
        host_wr(1'b0, 8'h14);
        host_wr(1'b1, 8'h77);
        wait_rx(100);
        host_rd(1'b1, v);
        chk("R12 resumes after reset", v, 8'h77);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule